// File: doc/BRIEF.md
# Split-Stream Bidirectional Fetch Sequencer

This block steers instruction fetch for a core whose code is split into two streams sharing one region of memory. A taken branch supplies a single entry address. From that address the compute stream is read toward higher addresses and the control/memory stream toward lower addresses. Each side keeps its own pointer. After every instruction, each pointer moves by the byte length found in that instruction's fixed header. The two pointers never step by an implicit amount.

Every cycle that the sequencer is running and not stalled, it registers one bundle. A bundle pairs one half from each side. Each half carries its start address, its byte length and its byte window, with the bytes beyond the instruction's end cleared. The surrounding logic exposes both pointers and returns the matching byte windows. For the compute side, window byte 0 is the byte at the pointer and later bytes lie above it. For the control side, window byte 0 is the byte just below the pointer and later bytes lie further down.

Top module: `split_fetch_seq`

## Requirements
- R1: After reset, both pointers read 0, `active` is 0 and `issue_valid` is 0.
- R2: When `br_valid` is high at a clock edge, both `exe_ptr` and `flw_ptr` equal `br_target` after that edge, and `active` becomes 1.
- R3: A branch flushes the bundle stage. `issue_valid` is 0 in the cycle after a branch is accepted, even when `stall` is high at the same time.
- R4: On each running, unstalled cycle, `exe_issue_addr` takes the old `exe_ptr` and `exe_ptr` grows by that side's length.
- R5: On each running, unstalled cycle, `flw_ptr` shrinks by that side's length and `flw_issue_addr` takes the new, lower pointer value. The instruction occupies the bytes just below the old pointer.
- R6: An instruction's length is bits [3:0] of window byte 0 (window bits [3:0]); bits [7:4] of the header are ignored. A value below the minimum length (2 by default) is raised to the minimum.
- R7: The two sides advance independently. After any sequence of steps, `exe_ptr - flw_ptr` equals the sum of all lengths consumed on both sides since the entry.
- R8: Both halves of a bundle are presented together under one `issue_valid`, along with each side's length.
- R9: While `stall` is high and no branch is present, both pointers and the whole bundle output hold their values, whatever the windows carry.
- R10: In each bundle half, window bytes at index length or higher read as zero, and lower-index bytes pass unchanged.
- R11: Until the first branch, the pointers do not move and no bundle is issued. No implicit increment exists.
- R12: Pointer and address arithmetic wraps modulo 2^ADDR_W in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze both pointers and the bundle stage |
| br_valid | input | 1 | Taken branch or entry this cycle |
| br_target | input | ADDR_W | Single entry address for both streams |
| exe_win | input | 8*WIN_BYTES | Bytes upward from `exe_ptr`, byte 0 in bits [7:0] |
| flw_win | input | 8*WIN_BYTES | Bytes downward from `flw_ptr - 1`, byte 0 in bits [7:0] |
| active | output | 1 | Sequencer has been given an entry point |
| exe_ptr | output | ADDR_W | Compute-stream pointer |
| flw_ptr | output | ADDR_W | Control-stream pointer |
| issue_valid | output | 1 | Registered bundle is valid |
| exe_issue_addr | output | ADDR_W | Start address of the compute half |
| exe_issue_len | output | LEN_W | Byte length of the compute half |
| exe_issue_bytes | output | 8*WIN_BYTES | Compute half bytes, beyond-length bytes cleared |
| flw_issue_addr | output | ADDR_W | Lowest address of the control half |
| flw_issue_len | output | LEN_W | Byte length of the control half |
| flw_issue_bytes | output | 8*WIN_BYTES | Control half bytes, beyond-length bytes cleared |

## Verification
The bound checker watches the following on every cycle: pointer loading and bundle flush after a branch, the per-step pointer arithmetic on both sides against the issued lengths, freezing under stall, immobility before the first entry, and the minimum-length floor. The byte masking, the decoding of header bits and the independent accumulation across long mixed-length runs are shown only by the bench. It sweeps every pair of header length codes and checks each issued window. Address wrap at both ends of the space is also reached only through dedicated bench scenarios.

// File: rtl/split_fetch_pkg.sv
package split_fetch_pkg;

    // Default configuration shared by the sequencer and its bench
    localparam int DEF_ADDR_W    = 16;
    localparam int DEF_WIN_BYTES = 8;
    localparam int DEF_LEN_W     = 4;
    localparam int DEF_MIN_LEN   = 2;

    // Direction a stream pointer walks from the entry address
    typedef enum logic {
        WALK_UP   = 1'b0,
        WALK_DOWN = 1'b1
    } walk_dir_e;

    // Per-cycle action shared by both stream pointers and the bundle stage
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_LOAD    = 2'd1,
        ACT_HOLD    = 2'd2,
        ACT_ADVANCE = 2'd3
    } seq_act_e;

    // Branch wins over stall; nothing moves before the first entry
    function automatic seq_act_e decide_action(input logic br,
                                               input logic stall,
                                               input logic running);
        if (br)
            return ACT_LOAD;
        else if (!running)
            return ACT_IDLE;
        else if (stall)
            return ACT_HOLD;
        else
            return ACT_ADVANCE;
    endfunction

endpackage

// File: rtl/sf_ctrl.sv
module sf_ctrl
    import split_fetch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     br_valid,
    input  logic     stall,
    output seq_act_e act,
    output logic     running
);

    logic running_q;

    always_ff @(posedge clk) begin
        if (rst)
            running_q <= 1'b0;
        else if (br_valid)
            running_q <= 1'b1;
    end

    assign running = running_q;
    assign act     = decide_action(br_valid, stall, running_q);

endmodule

// File: rtl/sf_side.sv
module sf_side
    import split_fetch_pkg::*;
#(
    parameter int        ADDR_W    = DEF_ADDR_W,
    parameter int        WIN_BYTES = DEF_WIN_BYTES,
    parameter int        LEN_W     = DEF_LEN_W,
    parameter int        MIN_LEN   = DEF_MIN_LEN,
    parameter walk_dir_e DIR       = WALK_UP
) (
    input  logic                   clk,
    input  logic                   rst,
    input  seq_act_e               act,
    input  logic [ADDR_W-1:0]      target,
    input  logic [8*WIN_BYTES-1:0] win,
    output logic [ADDR_W-1:0]      ptr,
    output logic [ADDR_W-1:0]      fetch_addr,
    output logic [LEN_W-1:0]       len,
    output logic [8*WIN_BYTES-1:0] kept
);

    localparam int              WIN_W   = 8 * WIN_BYTES;
    localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] next_ptr;
    logic [LEN_W-1:0]  hdr_len;

    // Shift count sits in the low bits of the byte nearest the pointer
    assign hdr_len = win[LEN_W-1:0];
    assign len     = (hdr_len < MIN_L) ? MIN_L : hdr_len;

    generate
        if (DIR == WALK_UP) begin : g_up
            assign next_ptr   = ptr_q + ADDR_W'(len);
            assign fetch_addr = ptr_q;
        end else begin : g_down
            assign next_ptr   = ptr_q - ADDR_W'(len);
            assign fetch_addr = next_ptr;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            case (act)
                ACT_LOAD:    ptr_q <= target;
                ACT_ADVANCE: ptr_q <= next_ptr;
                default:     ptr_q <= ptr_q;
            endcase
        end
    end

    assign ptr = ptr_q;

    // Clear window bytes that lie past the end of this instruction
    generate
        for (genvar g = 0; g < WIN_BYTES; g++) begin : g_mask
            assign kept[8*g +: 8] = (32'(g) < 32'(len)) ? win[8*g +: 8] : 8'h00;
        end
    endgenerate

    logic unused_w;
    assign unused_w = ^{WIN_W};

endmodule

// File: rtl/sf_issue.sv
module sf_issue
    import split_fetch_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int WIN_BYTES = DEF_WIN_BYTES,
    parameter int LEN_W     = DEF_LEN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  seq_act_e               act,
    input  logic [ADDR_W-1:0]      exe_addr,
    input  logic [LEN_W-1:0]       exe_len,
    input  logic [8*WIN_BYTES-1:0] exe_bytes,
    input  logic [ADDR_W-1:0]      flw_addr,
    input  logic [LEN_W-1:0]       flw_len,
    input  logic [8*WIN_BYTES-1:0] flw_bytes,
    output logic                   valid,
    output logic [ADDR_W-1:0]      exe_addr_q,
    output logic [LEN_W-1:0]       exe_len_q,
    output logic [8*WIN_BYTES-1:0] exe_bytes_q,
    output logic [ADDR_W-1:0]      flw_addr_q,
    output logic [LEN_W-1:0]       flw_len_q,
    output logic [8*WIN_BYTES-1:0] flw_bytes_q
);

    typedef struct packed {
        logic [ADDR_W-1:0]      addr;
        logic [LEN_W-1:0]       len;
        logic [8*WIN_BYTES-1:0] bytes;
    } half_t;

    half_t exe_q, flw_q;
    logic  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            exe_q   <= '0;
            flw_q   <= '0;
        end else begin
            case (act)
                ACT_ADVANCE: begin
                    valid_q <= 1'b1;
                    exe_q   <= '{addr: exe_addr, len: exe_len, bytes: exe_bytes};
                    flw_q   <= '{addr: flw_addr, len: flw_len, bytes: flw_bytes};
                end
                ACT_HOLD: begin
                    valid_q <= valid_q;
                end
                default: begin
                    // Load flushes the in-flight bundle; idle issues nothing
                    valid_q <= 1'b0;
                end
            endcase
        end
    end

    assign valid       = valid_q;
    assign exe_addr_q  = exe_q.addr;
    assign exe_len_q   = exe_q.len;
    assign exe_bytes_q = exe_q.bytes;
    assign flw_addr_q  = flw_q.addr;
    assign flw_len_q   = flw_q.len;
    assign flw_bytes_q = flw_q.bytes;

endmodule

// File: rtl/split_fetch_seq.sv
module split_fetch_seq
    import split_fetch_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int WIN_BYTES = DEF_WIN_BYTES,
    parameter int LEN_W     = DEF_LEN_W,
    parameter int MIN_LEN   = DEF_MIN_LEN
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   stall,
    input  logic                   br_valid,
    input  logic [ADDR_W-1:0]      br_target,
    input  logic [8*WIN_BYTES-1:0] exe_win,
    input  logic [8*WIN_BYTES-1:0] flw_win,
    output logic                   active,
    output logic [ADDR_W-1:0]      exe_ptr,
    output logic [ADDR_W-1:0]      flw_ptr,
    output logic                   issue_valid,
    output logic [ADDR_W-1:0]      exe_issue_addr,
    output logic [LEN_W-1:0]       exe_issue_len,
    output logic [8*WIN_BYTES-1:0] exe_issue_bytes,
    output logic [ADDR_W-1:0]      flw_issue_addr,
    output logic [LEN_W-1:0]       flw_issue_len,
    output logic [8*WIN_BYTES-1:0] flw_issue_bytes
);

    localparam int WIN_W = 8 * WIN_BYTES;

    seq_act_e          act;
    logic [ADDR_W-1:0] exe_fa, flw_fa;
    logic [LEN_W-1:0]  exe_len, flw_len;
    logic [WIN_W-1:0]  exe_kept, flw_kept;

    sf_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .br_valid (br_valid),
        .stall    (stall),
        .act      (act),
        .running  (active)
    );

    sf_side #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W),
        .MIN_LEN(MIN_LEN), .DIR(WALK_UP)
    ) u_exe (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .target     (br_target),
        .win        (exe_win),
        .ptr        (exe_ptr),
        .fetch_addr (exe_fa),
        .len        (exe_len),
        .kept       (exe_kept)
    );

    sf_side #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W),
        .MIN_LEN(MIN_LEN), .DIR(WALK_DOWN)
    ) u_flw (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .target     (br_target),
        .win        (flw_win),
        .ptr        (flw_ptr),
        .fetch_addr (flw_fa),
        .len        (flw_len),
        .kept       (flw_kept)
    );

    sf_issue #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W)
    ) u_issue (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .exe_addr    (exe_fa),
        .exe_len     (exe_len),
        .exe_bytes   (exe_kept),
        .flw_addr    (flw_fa),
        .flw_len     (flw_len),
        .flw_bytes   (flw_kept),
        .valid       (issue_valid),
        .exe_addr_q  (exe_issue_addr),
        .exe_len_q   (exe_issue_len),
        .exe_bytes_q (exe_issue_bytes),
        .flw_addr_q  (flw_issue_addr),
        .flw_len_q   (flw_issue_len),
        .flw_bytes_q (flw_issue_bytes)
    );

endmodule

// File: rtl/split_fetch_seq_chk.sv
module split_fetch_seq_chk #(
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 4,
    parameter int MIN_LEN = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              br_valid,
    input logic [ADDR_W-1:0] br_target,
    input logic              active,
    input logic [ADDR_W-1:0] exe_ptr,
    input logic [ADDR_W-1:0] flw_ptr,
    input logic              issue_valid,
    input logic [ADDR_W-1:0] exe_issue_addr,
    input logic [LEN_W-1:0]  exe_issue_len,
    input logic [ADDR_W-1:0] flw_issue_addr,
    input logic [LEN_W-1:0]  flw_issue_len
);

    // R2
    entry_load_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> (exe_ptr == $past(br_target)) && (flw_ptr == $past(br_target)) && active);

    // R3
    branch_flush_chk: assert property (@(posedge clk) disable iff (rst)
        br_valid |=> !issue_valid);

    // R4
    exe_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !stall && !br_valid) |=>
            (exe_issue_addr == $past(exe_ptr)) &&
            (exe_ptr == $past(exe_ptr) + ADDR_W'(exe_issue_len)));

    // R5
    flw_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !stall && !br_valid) |=>
            (flw_ptr == $past(flw_ptr) - ADDR_W'(flw_issue_len)) &&
            (flw_issue_addr == flw_ptr));

    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (stall && !br_valid) |=>
            $stable(exe_ptr) && $stable(flw_ptr) && $stable(issue_valid) &&
            $stable(exe_issue_addr) && $stable(flw_issue_addr));

    // R11
    idle_still_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !br_valid) |=> $stable(exe_ptr) && $stable(flw_ptr) && !issue_valid);

    // R6
    min_len_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (int'(exe_issue_len) >= MIN_LEN) && (int'(flw_issue_len) >= MIN_LEN));

    // R8
    paired_issue_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(issue_valid) |-> $past(active) && !$past(br_valid));

endmodule

bind split_fetch_seq split_fetch_seq_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .stall          (stall),
    .br_valid       (br_valid),
    .br_target      (br_target),
    .active         (active),
    .exe_ptr        (exe_ptr),
    .flw_ptr        (flw_ptr),
    .issue_valid    (issue_valid),
    .exe_issue_addr (exe_issue_addr),
    .exe_issue_len  (exe_issue_len),
    .flw_issue_addr (flw_issue_addr),
    .flw_issue_len  (flw_issue_len)
);

// File: tb/split_fetch_seq_test.sv
module split_fetch_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int WB = 8;
    localparam int LW = 4;
    localparam int MINL = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          stall;
    logic          br_valid;
    logic [AW-1:0] br_target;
    logic [63:0]   exe_win, flw_win;
    logic          active;
    logic [AW-1:0] exe_ptr, flw_ptr;
    logic          issue_valid;
    logic [AW-1:0] exe_issue_addr, flw_issue_addr;
    logic [LW-1:0] exe_issue_len, flw_issue_len;
    logic [63:0]   exe_issue_bytes, flw_issue_bytes;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [AW-1:0] m_e, m_f, m_entry;
    int            consumed;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_fetch_seq #(.ADDR_W(AW), .WIN_BYTES(WB), .LEN_W(LW), .MIN_LEN(MINL)) uut (
        .clk(clk), .rst(rst), .stall(stall), .br_valid(br_valid), .br_target(br_target),
        .exe_win(exe_win), .flw_win(flw_win), .active(active),
        .exe_ptr(exe_ptr), .flw_ptr(flw_ptr), .issue_valid(issue_valid),
        .exe_issue_addr(exe_issue_addr), .exe_issue_len(exe_issue_len),
        .exe_issue_bytes(exe_issue_bytes), .flw_issue_addr(flw_issue_addr),
        .flw_issue_len(flw_issue_len), .flw_issue_bytes(flw_issue_bytes)
    );

    task automatic chk(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
        end
    endtask

    // Header byte: upper nibble is noise, low nibble is the length code
    function automatic logic [63:0] mkwin(input logic [7:0] seed, input logic [3:0] code);
        logic [63:0] w;
        w[7:0] = {seed[3:0] ^ 4'hA, code};
        for (int i = 1; i < WB; i++) w[8*i +: 8] = seed + 8'(i * 37);
        return w;
    endfunction

    function automatic logic [3:0] lenof(input logic [3:0] code);
        return (int'(code) < MINL) ? 4'(MINL) : code;
    endfunction

    function automatic logic [63:0] masked(input logic [63:0] w, input logic [3:0] l);
        logic [63:0] r;
        for (int i = 0; i < WB; i++) r[8*i +: 8] = (i < int'(l)) ? w[8*i +: 8] : 8'h00;
        return r;
    endfunction

    task automatic branch(input logic [AW-1:0] t, input logic with_stall);
        br_valid  = 1'b1;
        br_target = t;
        stall     = with_stall;
        @(posedge clk); #1;
        br_valid = 1'b0;
        stall    = 1'b0;
        chk("R2", "exe_ptr after entry", exe_ptr, t);
        chk("R2", "flw_ptr after entry", flw_ptr, t);
        chk("R2", "active after entry", active, 1);
        chk("R3", "issue_valid after entry", issue_valid, 0);
        m_e = t; m_f = t; m_entry = t; consumed = 0;
    endtask

    task automatic step(input logic [3:0] ec, input logic [3:0] fc,
                        input logic [7:0] es, input logic [7:0] fs);
        logic [3:0]  el, fl;
        logic [63:0] ew, fw;
        ew = mkwin(es, ec); fw = mkwin(fs, fc);
        el = lenof(ec);     fl = lenof(fc);
        exe_win = ew; flw_win = fw;
        @(posedge clk); #1;
        chk("R8", "issue_valid", issue_valid, 1);
        chk("R4", "exe_issue_addr", exe_issue_addr, m_e);
        chk("R6", "exe_issue_len", exe_issue_len, el);
        chk("R5", "flw_issue_addr", flw_issue_addr, AW'(m_f - AW'(fl)));
        chk("R6", "flw_issue_len", flw_issue_len, fl);
        chk("R10", "exe_issue_bytes", exe_issue_bytes, masked(ew, el));
        chk("R10", "flw_issue_bytes", flw_issue_bytes, masked(fw, fl));
        m_e = m_e + AW'(el);
        m_f = m_f - AW'(fl);
        consumed = consumed + int'(el) + int'(fl);
        chk("R4", "exe_ptr", exe_ptr, m_e);
        chk("R5", "flw_ptr", flw_ptr, m_f);
        chk("R7", "pointer spread", AW'(exe_ptr - flw_ptr), AW'(consumed));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] he, hf, hea, hfa;
        logic [63:0]   heb, hfb;
        rst = 1'b1; stall = 1'b0; br_valid = 1'b0; br_target = '0;
        exe_win = '0; flw_win = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1", "exe_ptr reset", exe_ptr, 0);
        chk("R1", "flw_ptr reset", flw_ptr, 0);
        chk("R1", "active reset", active, 0);
        chk("R1", "issue_valid reset", issue_valid, 0);

        // No entry yet: windows carry lengths, nothing may move
        exe_win = mkwin(8'h31, 4'd7); flw_win = mkwin(8'h52, 4'd9);
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            chk("R11", "exe_ptr idle", exe_ptr, 0);
            chk("R11", "flw_ptr idle", flw_ptr, 0);
            chk("R11", "issue_valid idle", issue_valid, 0);
        end

        // Sweep every pair of length codes from a mid-space entry
        branch(16'h8000, 1'b0);
        for (int e = 0; e < 16; e++)
            for (int f = 0; f < 16; f++)
                step(4'(e), 4'(f), 8'(e * 16 + f), 8'(255 - e * 16 - f));

        // Stall freezes everything while windows change
        step(4'd5, 4'd3, 8'h11, 8'h22);
        he = exe_ptr; hf = flw_ptr; hea = exe_issue_addr; hfa = flw_issue_addr;
        heb = exe_issue_bytes; hfb = flw_issue_bytes;
        stall = 1'b1;
        for (int k = 0; k < 3; k++) begin
            exe_win = mkwin(8'(k), 4'd12); flw_win = mkwin(8'(k + 9), 4'd14);
            @(posedge clk); #1;
            chk("R9", "exe_ptr stalled", exe_ptr, he);
            chk("R9", "flw_ptr stalled", flw_ptr, hf);
            chk("R9", "issue_valid stalled", issue_valid, 1);
            chk("R9", "exe_issue_addr stalled", exe_issue_addr, hea);
            chk("R9", "flw_issue_addr stalled", flw_issue_addr, hfa);
            chk("R9", "exe bytes stalled", exe_issue_bytes, heb);
            chk("R9", "flw bytes stalled", flw_issue_bytes, hfb);
        end
        stall = 1'b0;
        m_e = he; m_f = hf;
        step(4'd4, 4'd6, 8'h33, 8'h44);

        // Branch accepted together with stall still flushes and loads
        branch(16'h1234, 1'b1);
        step(4'd8, 4'd2, 8'h55, 8'h66);

        // Wrap at the bottom of the space on the downward side
        branch(16'h0003, 1'b0);
        step(4'd3, 4'd8, 8'h77, 8'h88);
        chk("R12", "flw_ptr wrapped low", flw_ptr, 16'hFFFB);
        chk("R12", "flw_issue_addr wrapped low", flw_issue_addr, 16'hFFFB);

        // Wrap at the top of the space on the upward side
        branch(16'hFFFE, 1'b0);
        step(4'd5, 4'd2, 8'h99, 8'hAA);
        chk("R12", "exe_ptr wrapped high", exe_ptr, 16'h0003);
        chk("R12", "exe_issue_addr before wrap", exe_issue_addr, 16'hFFFE);

        summary();
        $finish;
    end

endmodule